// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This block decides how a processor core enters a trap and updates the saved-state registers that go with it. Each cycle it looks at three kinds of request: a debug request carrying a debug cause, a synchronous exception carrying a cause code and an optional faulting address, and an interrupt that the interrupt logic has already accepted at some level. From the status word and the current PC it picks one entry, classifies it, and commits all state updates on a single clock edge. The kinds are user, kernel, double, high-level and debug. It returns the new status word and the target vector address, which can be relocated against a runtime vector base.

Saved program counters are held in a bank with one entry per interrupt level, starting at level 1. Saved status words are held in a second bank that starts at level 2. There is also a dedicated double-exception PC register, a cause register, a faulting-address register and a debug-cause register. Fetch redirection, pipeline flushing and the register file are handled elsewhere; the core only needs `taken_o` and `vector_o`.

The controller is a two-state machine. In `ST_IDLE` it evaluates requests; a request that qualifies causes the `IDLE_TO_ENTERED` transition, and all registers are written on that edge. In `ST_ENTERED`, which lasts exactly one cycle, `taken_o` is high and every request is ignored. The `ENTERED_TO_IDLE` transition always follows. When nothing qualifies in `ST_IDLE`, the `IDLE_HOLD` transition keeps the state where it is.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, `taken_o`, `vector_o`, `ps_o`, both banks, `depc_o`, `exccause_o`, `excvaddr_o` and `dbgcause_o` are all zero.
- R2: The status word has the interrupt level in bits [3:0], exception mode at bit 4 and user mode at bit 5. A synchronous exception with exception mode clear saves `pc_i` into level-1 entry of the PC bank (bits [AW-1:0] of `epc_bank_o`). It targets the user vector (offset 0x340) when user mode is set and the kernel vector (offset 0x300) otherwise.
- R3: Every general entry (user, kernel or double) writes the cause into `exccause_o` and returns `ps_o` equal to `ps_i` with bit 4 set.
- R4: A general entry taken with exception mode already set targets the double vector (offset 0x3C0). With the double PC register present (default), `pc_i` goes to `depc_o` and level-1 PC entry is left unchanged.
- R5: `excvaddr_o` takes `exc_addr_i` only on a synchronous exception with `exc_addr_valid_i` high; otherwise it keeps its value.
- R6: An interrupt at level L≥2 saves `pc_i` into PC bank entry L and `ps_i` into status bank entry L (bits [(L-2)*8+7:(L-2)*8] of `eps_bank_o`). `ps_o` equals `ps_i` with bits [3:0]=L and bit 4 set. The target is offset 0x180+(L-2)*0x40, and `exccause_o` is unchanged.
- R7: A level-1 interrupt is entered as a general entry with cause 4, using the same user, kernel or double selection.
- R8: An interrupt is taken only when its level is above `ps_i[3:0]` and no higher than NLEVEL (default 6); otherwise nothing is entered.
- R9: A debug entry uses DEBUG_LEVEL (default 6). It saves `pc_i` and `ps_i` into that level's bank entries, writes `dbgcause_o`, sets `ps_o[3:0]` to DEBUG_LEVEL with bit 4 set, and targets offset 0x2C0.
- R10: A debug request is honoured only when `ps_i[3:0]` is below DEBUG_LEVEL; otherwise it is ignored and the next request in priority is considered.
- R11: Priority is debug, then synchronous exception, then interrupt.
- R12: With relocation enabled, `vector_o` = default vector − DEF_VECBASE (0x4000_0000) + `vecbase_i`, where default vector = DEF_VECBASE + offset.
- R13: `taken_o` is high for exactly the one cycle after the commit edge, and outputs change only on that edge. Requests presented while `taken_o` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_req_i | input | 1 | Debug entry request |
| dbg_cause_i | input | 6 | Debug cause code |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_cause_i | input | 6 | Exception cause code |
| exc_addr_valid_i | input | 1 | Exception carries a faulting address |
| exc_addr_i | input | AW | Faulting address |
| irq_req_i | input | 1 | Accepted interrupt present |
| irq_level_i | input | 4 | Level of that interrupt |
| pc_i | input | AW | PC of the interrupted instruction |
| ps_i | input | 8 | Current status word |
| vecbase_i | input | AW | Runtime vector base |
| taken_o | output | 1 | One-cycle pulse after an entry commits |
| vector_o | output | AW | Target vector of the last entry |
| ps_o | output | 8 | New status word of the last entry |
| epc_bank_o | output | NLEVEL*AW | Saved PC bank, level L at slice L-1 |
| eps_bank_o | output | (NLEVEL-1)*8 | Saved status bank, level L at slice L-2 |
| depc_o | output | AW | Double-exception saved PC |
| exccause_o | output | 6 | Cause of the last general entry |
| excvaddr_o | output | AW | Faulting address |
| dbgcause_o | output | 6 | Cause of the last debug entry |

## Verification
A table of request combinations walks the general path with the status word cleared, with user mode set, with exception mode set, and with both set and other bits high. Comparing vector, status and cause across these rows separates the kernel, user and double selections and confirms that untouched status bits survive. Interrupt rows use levels 1, 2, 3, 6 and 7 against different current levels. They separate the conversion of a level-1 interrupt, the banked high-level entry and the two rejection limits. Rows that combine requests, with the current level at and below the debug level, show the priority order and the debug gate. Directed steps then read individual bank entries, the faulting-address register, the double PC, a request made during the taken cycle, and relocation with the base equal to its default.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int PS_W     = 8;
    localparam int LVL_W    = 4;
    localparam int CAUSE_W  = 6;
    localparam int EXCM_POS = 4;
    localparam int UM_POS   = 5;

    typedef enum logic [2:0] {
        ENT_NONE,
        ENT_USER,
        ENT_KERNEL,
        ENT_DOUBLE,
        ENT_HIGH,
        ENT_DEBUG
    } entry_kind_e;

    typedef struct packed {
        entry_kind_e       kind;
        logic [LVL_W-1:0]  level;
        logic              from_irq;  // general entry made from a level-1 interrupt
        logic              from_exc;  // general entry made from a synchronous exception
    } entry_dec_t;

    typedef enum logic {
        ST_IDLE,
        ST_ENTERED
    } ctl_state_e;

endpackage

// File: rtl/exc_entry_classify.sv
module exc_entry_classify
    import exc_entry_pkg::*;
#(
    parameter int NLEVEL      = 6,
    parameter int DEBUG_LEVEL = 6
) (
    input  logic             dbg_req_i,
    input  logic             exc_req_i,
    input  logic             irq_req_i,
    input  logic [LVL_W-1:0] irq_level_i,
    input  logic [PS_W-1:0]  ps_i,
    output entry_dec_t       dec_o
);

    localparam logic [LVL_W-1:0] DBG_LVL = LVL_W'(DEBUG_LEVEL);
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NLEVEL);
    localparam logic [LVL_W-1:0] ONE_LVL = LVL_W'(1);

    logic [LVL_W-1:0] cur_lvl;
    logic             dbg_ok;
    logic             irq_ok;
    entry_kind_e      general_kind;

    assign cur_lvl = ps_i[LVL_W-1:0];

    always_comb begin
        dbg_ok = dbg_req_i && (cur_lvl < DBG_LVL);
        irq_ok = irq_req_i && (irq_level_i > cur_lvl) && (irq_level_i <= TOP_LVL);

        if (ps_i[EXCM_POS]) begin
            general_kind = ENT_DOUBLE;
        end else if (ps_i[UM_POS]) begin
            general_kind = ENT_USER;
        end else begin
            general_kind = ENT_KERNEL;
        end

        dec_o.kind     = ENT_NONE;
        dec_o.level    = '0;
        dec_o.from_irq = 1'b0;
        dec_o.from_exc = 1'b0;

        if (dbg_ok) begin
            dec_o.kind  = ENT_DEBUG;
            dec_o.level = DBG_LVL;
        end else if (exc_req_i) begin
            dec_o.kind     = general_kind;
            dec_o.level    = ONE_LVL;
            dec_o.from_exc = 1'b1;
        end else if (irq_ok) begin
            if (irq_level_i == ONE_LVL) begin
                dec_o.kind     = general_kind;
                dec_o.level    = ONE_LVL;
                dec_o.from_irq = 1'b1;
            end else begin
                dec_o.kind  = ENT_HIGH;
                dec_o.level = irq_level_i;
            end
        end
    end

endmodule

// File: rtl/exc_entry_vector.sv
module exc_entry_vector
    import exc_entry_pkg::*;
#(
    parameter int             AW              = 32,
    parameter int             NLEVEL          = 6,
    parameter bit             RELOC           = 1'b1,
    parameter logic [AW-1:0]  DEF_VECBASE     = 32'h4000_0000,
    parameter logic [AW-1:0]  USER_VEC        = 32'h4000_0340,
    parameter logic [AW-1:0]  KERNEL_VEC      = 32'h4000_0300,
    parameter logic [AW-1:0]  DOUBLE_VEC      = 32'h4000_03C0,
    parameter logic [AW-1:0]  DEBUG_VEC       = 32'h4000_02C0,
    parameter logic [AW-1:0]  HIGH_VEC_BASE   = 32'h4000_0180,
    parameter logic [AW-1:0]  HIGH_VEC_STRIDE = 32'h0000_0040
) (
    input  entry_kind_e       kind_i,
    input  logic [LVL_W-1:0]  level_i,
    input  logic [AW-1:0]     vecbase_i,
    output logic [AW-1:0]     vector_o
);

    logic [AW-1:0] high_vec [2:NLEVEL];
    logic [AW-1:0] high_sel;
    logic [AW-1:0] raw_vec;

    for (genvar l = 2; l <= NLEVEL; l++) begin : g_high_vec
        assign high_vec[l] = HIGH_VEC_BASE + HIGH_VEC_STRIDE * AW'(l - 2);
    end

    always_comb begin
        high_sel = '0;
        for (int l = 2; l <= NLEVEL; l++) begin
            if (level_i == LVL_W'(l)) begin
                high_sel = high_vec[l];
            end
        end
    end

    always_comb begin
        case (kind_i)
            ENT_USER:   raw_vec = USER_VEC;
            ENT_KERNEL: raw_vec = KERNEL_VEC;
            ENT_DOUBLE: raw_vec = DOUBLE_VEC;
            ENT_DEBUG:  raw_vec = DEBUG_VEC;
            ENT_HIGH:   raw_vec = high_sel;
            default:    raw_vec = '0;
        endcase
    end

    if (RELOC) begin : g_reloc
        assign vector_o = raw_vec - DEF_VECBASE + vecbase_i;
    end else begin : g_fixed
        assign vector_o = raw_vec;
    end

endmodule

// File: rtl/exc_entry_bank.sv
module exc_entry_bank
    import exc_entry_pkg::*;
#(
    parameter int                  AW       = 32,
    parameter int                  NLEVEL   = 6,
    parameter bit                  HAS_DEPC = 1'b1,
    parameter logic [CAUSE_W-1:0]  L1_CAUSE = 6'd4
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      we_i,
    input  entry_dec_t                dec_i,
    input  logic [AW-1:0]             pc_i,
    input  logic [PS_W-1:0]           ps_i,
    input  logic [CAUSE_W-1:0]        cause_i,
    input  logic                      addr_valid_i,
    input  logic [AW-1:0]             addr_i,
    input  logic [CAUSE_W-1:0]        dbg_cause_i,
    output logic [NLEVEL*AW-1:0]      epc_bank_o,
    output logic [(NLEVEL-1)*PS_W-1:0] eps_bank_o,
    output logic [AW-1:0]             depc_o,
    output logic [CAUSE_W-1:0]        exccause_o,
    output logic [AW-1:0]             excvaddr_o,
    output logic [CAUSE_W-1:0]        dbgcause_o,
    output logic [PS_W-1:0]           ps_o
);

    logic            general_entry;
    logic            banked_entry;
    logic [PS_W-1:0] ps_new;

    assign general_entry = (dec_i.kind == ENT_USER) || (dec_i.kind == ENT_KERNEL) ||
                           (dec_i.kind == ENT_DOUBLE);
    assign banked_entry  = (dec_i.kind == ENT_HIGH) || (dec_i.kind == ENT_DEBUG);

    always_comb begin
        ps_new = ps_i;
        if (banked_entry) begin
            ps_new[LVL_W-1:0] = dec_i.level;
        end
        ps_new[EXCM_POS] = 1'b1;
    end

    for (genvar l = 1; l <= NLEVEL; l++) begin : g_epc
        logic          hit;
        logic [AW-1:0] epc_q;
        if (l == 1) begin : g_lvl1
            assign hit = general_entry && !((dec_i.kind == ENT_DOUBLE) && HAS_DEPC);
        end else begin : g_lvlN
            assign hit = banked_entry && (dec_i.level == LVL_W'(l));
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                epc_q <= '0;
            end else if (we_i && hit) begin
                epc_q <= pc_i;
            end
        end
        assign epc_bank_o[(l-1)*AW +: AW] = epc_q;
    end

    for (genvar l = 2; l <= NLEVEL; l++) begin : g_eps
        logic            hit;
        logic [PS_W-1:0] eps_q;
        assign hit = banked_entry && (dec_i.level == LVL_W'(l));
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                eps_q <= '0;
            end else if (we_i && hit) begin
                eps_q <= ps_i;
            end
        end
        assign eps_bank_o[(l-2)*PS_W +: PS_W] = eps_q;
    end

    if (HAS_DEPC) begin : g_depc
        logic [AW-1:0] depc_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                depc_q <= '0;
            end else if (we_i && (dec_i.kind == ENT_DOUBLE)) begin
                depc_q <= pc_i;
            end
        end
        assign depc_o = depc_q;
    end else begin : g_no_depc
        assign depc_o = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            exccause_o <= '0;
            excvaddr_o <= '0;
            dbgcause_o <= '0;
            ps_o       <= '0;
        end else if (we_i) begin
            if (general_entry) begin
                exccause_o <= dec_i.from_irq ? L1_CAUSE : cause_i;
            end
            if (dec_i.from_exc && addr_valid_i) begin
                excvaddr_o <= addr_i;
            end
            if (dec_i.kind == ENT_DEBUG) begin
                dbgcause_o <= dbg_cause_i;
            end
            if (dec_i.kind != ENT_NONE) begin
                ps_o <= ps_new;
            end
        end
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int                  AW              = 32,
    parameter int                  NLEVEL          = 6,
    parameter int                  DEBUG_LEVEL     = 6,
    parameter bit                  HAS_DEPC        = 1'b1,
    parameter bit                  RELOC           = 1'b1,
    parameter logic [CAUSE_W-1:0]  L1_CAUSE        = 6'd4,
    parameter logic [AW-1:0]       DEF_VECBASE     = 32'h4000_0000,
    parameter logic [AW-1:0]       USER_VEC        = 32'h4000_0340,
    parameter logic [AW-1:0]       KERNEL_VEC      = 32'h4000_0300,
    parameter logic [AW-1:0]       DOUBLE_VEC      = 32'h4000_03C0,
    parameter logic [AW-1:0]       DEBUG_VEC       = 32'h4000_02C0,
    parameter logic [AW-1:0]       HIGH_VEC_BASE   = 32'h4000_0180,
    parameter logic [AW-1:0]       HIGH_VEC_STRIDE = 32'h0000_0040
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        dbg_req_i,
    input  logic [CAUSE_W-1:0]          dbg_cause_i,
    input  logic                        exc_req_i,
    input  logic [CAUSE_W-1:0]          exc_cause_i,
    input  logic                        exc_addr_valid_i,
    input  logic [AW-1:0]               exc_addr_i,
    input  logic                        irq_req_i,
    input  logic [LVL_W-1:0]            irq_level_i,
    input  logic [AW-1:0]               pc_i,
    input  logic [PS_W-1:0]             ps_i,
    input  logic [AW-1:0]               vecbase_i,
    output logic                        taken_o,
    output logic [AW-1:0]               vector_o,
    output logic [PS_W-1:0]             ps_o,
    output logic [NLEVEL*AW-1:0]        epc_bank_o,
    output logic [(NLEVEL-1)*PS_W-1:0]  eps_bank_o,
    output logic [AW-1:0]               depc_o,
    output logic [CAUSE_W-1:0]          exccause_o,
    output logic [AW-1:0]               excvaddr_o,
    output logic [CAUSE_W-1:0]          dbgcause_o
);

    ctl_state_e    state_q;
    ctl_state_e    state_d;
    entry_dec_t    dec;
    logic          commit;
    logic [AW-1:0] vec_next;
    logic [AW-1:0] vector_q;

    exc_entry_classify #(
        .NLEVEL      (NLEVEL),
        .DEBUG_LEVEL (DEBUG_LEVEL)
    ) u_classify (
        .dbg_req_i   (dbg_req_i),
        .exc_req_i   (exc_req_i),
        .irq_req_i   (irq_req_i),
        .irq_level_i (irq_level_i),
        .ps_i        (ps_i),
        .dec_o       (dec)
    );

    exc_entry_vector #(
        .AW              (AW),
        .NLEVEL          (NLEVEL),
        .RELOC           (RELOC),
        .DEF_VECBASE     (DEF_VECBASE),
        .USER_VEC        (USER_VEC),
        .KERNEL_VEC      (KERNEL_VEC),
        .DOUBLE_VEC      (DOUBLE_VEC),
        .DEBUG_VEC       (DEBUG_VEC),
        .HIGH_VEC_BASE   (HIGH_VEC_BASE),
        .HIGH_VEC_STRIDE (HIGH_VEC_STRIDE)
    ) u_vector (
        .kind_i    (dec.kind),
        .level_i   (dec.level),
        .vecbase_i (vecbase_i),
        .vector_o  (vec_next)
    );

    exc_entry_bank #(
        .AW       (AW),
        .NLEVEL   (NLEVEL),
        .HAS_DEPC (HAS_DEPC),
        .L1_CAUSE (L1_CAUSE)
    ) u_bank (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .we_i         (commit),
        .dec_i        (dec),
        .pc_i         (pc_i),
        .ps_i         (ps_i),
        .cause_i      (exc_cause_i),
        .addr_valid_i (exc_addr_valid_i),
        .addr_i       (exc_addr_i),
        .dbg_cause_i  (dbg_cause_i),
        .epc_bank_o   (epc_bank_o),
        .eps_bank_o   (eps_bank_o),
        .depc_o       (depc_o),
        .exccause_o   (exccause_o),
        .excvaddr_o   (excvaddr_o),
        .dbgcause_o   (dbgcause_o),
        .ps_o         (ps_o)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: IDLE_TO_ENTERED, IDLE_HOLD, ENTERED_TO_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (dec.kind != ENT_NONE) begin
                    state_d = ST_ENTERED;
                end
            end
            ST_ENTERED: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                taken_o = 1'b0;
                commit  = (dec.kind != ENT_NONE);
            end
            ST_ENTERED: begin
                taken_o = 1'b1;
                commit  = 1'b0;
            end
            default: begin
                taken_o = 1'b0;
                commit  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            vector_q <= '0;
        end else if (commit) begin
            vector_q <= vec_next;
        end
    end

    assign vector_o = vector_q;

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
    import exc_entry_pkg::*;
#(
    parameter int AW          = 32,
    parameter int NLEVEL      = 6,
    parameter int DEBUG_LEVEL = 6
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 dbg_req_i,
    input logic                 exc_req_i,
    input logic                 irq_req_i,
    input logic [LVL_W-1:0]     irq_level_i,
    input logic [PS_W-1:0]      ps_i,
    input logic                 taken_o,
    input logic [AW-1:0]        vector_o,
    input logic [PS_W-1:0]      ps_o,
    input logic [CAUSE_W-1:0]   exccause_o,
    input logic [NLEVEL*AW-1:0] epc_bank_o
);

    localparam logic [LVL_W-1:0] DBG_LVL = LVL_W'(DEBUG_LEVEL);
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NLEVEL);

    // R13
    taken_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        taken_o |=> !taken_o);

    // R13
    hold_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !taken_o |-> ($stable(exccause_o) && $stable(ps_o) &&
                      $stable(vector_o) && $stable(epc_bank_o)));

    // R3
    excm_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        taken_o |-> ps_o[EXCM_POS]);

    // R9
    dbg_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (taken_o && $past(dbg_req_i) && ($past(ps_i[LVL_W-1:0]) < DBG_LVL))
            |-> (ps_o[LVL_W-1:0] == DBG_LVL));

    // R8
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dbg_req_i && !exc_req_i && irq_req_i &&
         ((irq_level_i <= ps_i[LVL_W-1:0]) || (irq_level_i > TOP_LVL)))
            |=> !taken_o);

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(
    .AW          (AW),
    .NLEVEL      (NLEVEL),
    .DEBUG_LEVEL (DEBUG_LEVEL)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dbg_req_i   (dbg_req_i),
    .exc_req_i   (exc_req_i),
    .irq_req_i   (irq_req_i),
    .irq_level_i (irq_level_i),
    .ps_i        (ps_i),
    .taken_o     (taken_o),
    .vector_o    (vector_o),
    .ps_o        (ps_o),
    .exccause_o  (exccause_o),
    .epc_bank_o  (epc_bank_o)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
    import exc_entry_pkg::*;

    localparam int          CLK_PERIOD = 10;
    localparam int          AW         = 32;
    localparam int          NLEVEL     = 6;
    localparam logic [31:0] VB         = 32'h0010_0000;
    localparam logic [31:0] DEFB       = 32'h4000_0000;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic                        dbg_req = 1'b0;
    logic [5:0]                  dbg_cause = '0;
    logic                        exc_req = 1'b0;
    logic [5:0]                  exc_cause = '0;
    logic                        exc_addr_valid = 1'b0;
    logic [31:0]                 exc_addr = '0;
    logic                        irq_req = 1'b0;
    logic [3:0]                  irq_level = '0;
    logic [31:0]                 pc = '0;
    logic [7:0]                  ps = '0;
    logic [31:0]                 vecbase = VB;
    logic                        taken;
    logic [31:0]                 vector;
    logic [7:0]                  ps_out;
    logic [NLEVEL*AW-1:0]        epc_bank;
    logic [(NLEVEL-1)*8-1:0]     eps_bank;
    logic [31:0]                 depc;
    logic [5:0]                  exccause;
    logic [31:0]                 excvaddr;
    logic [5:0]                  dbgcause;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .dbg_req_i        (dbg_req),
        .dbg_cause_i      (dbg_cause),
        .exc_req_i        (exc_req),
        .exc_cause_i      (exc_cause),
        .exc_addr_valid_i (exc_addr_valid),
        .exc_addr_i       (exc_addr),
        .irq_req_i        (irq_req),
        .irq_level_i      (irq_level),
        .pc_i             (pc),
        .ps_i             (ps),
        .vecbase_i        (vecbase),
        .taken_o          (taken),
        .vector_o         (vector),
        .ps_o             (ps_out),
        .epc_bank_o       (epc_bank),
        .eps_bank_o       (eps_bank),
        .depc_o           (depc),
        .exccause_o       (exccause),
        .excvaddr_o       (excvaddr),
        .dbgcause_o       (dbgcause)
    );

    typedef struct packed {
        logic        dbg;
        logic        exc;
        logic        irq;
        logic [3:0]  lvl;
        logic [7:0]  ps;
        logic [5:0]  cause;
        logic        tk;
        logic [31:0] off;
        logic [7:0]  eps;
        logic [5:0]  ecause;
    } row_t;

    localparam int NROWS = 14;
    localparam row_t ROWS [NROWS] = '{
        // R2 kernel
        '{1'b0, 1'b1, 1'b0, 4'd0, 8'h00, 6'd9,  1'b1, 32'h300, 8'h10, 6'd9},
        // R2 user, R3
        '{1'b0, 1'b1, 1'b0, 4'd0, 8'h20, 6'd3,  1'b1, 32'h340, 8'h30, 6'd3},
        // R4 double
        '{1'b0, 1'b1, 1'b0, 4'd0, 8'h10, 6'd7,  1'b1, 32'h3C0, 8'h10, 6'd7},
        // R4 double with other bits kept, R3
        '{1'b0, 1'b1, 1'b0, 4'd0, 8'hB3, 6'd12, 1'b1, 32'h3C0, 8'hB3, 6'd12},
        // R7 level-1 irq, user
        '{1'b0, 1'b0, 1'b1, 4'd1, 8'h20, 6'd0,  1'b1, 32'h340, 8'h30, 6'd4},
        // R7 level-1 irq, kernel
        '{1'b0, 1'b0, 1'b1, 4'd1, 8'h00, 6'd0,  1'b1, 32'h300, 8'h10, 6'd4},
        // R6 level 3
        '{1'b0, 1'b0, 1'b1, 4'd3, 8'h21, 6'd0,  1'b1, 32'h1C0, 8'h33, 6'd4},
        // R8 level not above current: nothing changes
        '{1'b0, 1'b0, 1'b1, 4'd2, 8'h02, 6'd0,  1'b0, 32'h1C0, 8'h33, 6'd4},
        // R8 level above NLEVEL: nothing changes
        '{1'b0, 1'b0, 1'b1, 4'd7, 8'h00, 6'd0,  1'b0, 32'h1C0, 8'h33, 6'd4},
        // R9 debug
        '{1'b1, 1'b0, 1'b0, 4'd0, 8'h25, 6'd0,  1'b1, 32'h2C0, 8'h36, 6'd4},
        // R10 debug gated at level 6, R11 exception taken instead
        '{1'b1, 1'b1, 1'b0, 4'd0, 8'h06, 6'd5,  1'b1, 32'h300, 8'h16, 6'd5},
        // R11 debug wins over exception and irq
        '{1'b1, 1'b1, 1'b1, 4'd3, 8'h00, 6'd8,  1'b1, 32'h2C0, 8'h16, 6'd5},
        // R11 exception wins over irq
        '{1'b0, 1'b1, 1'b1, 4'd5, 8'h00, 6'd33, 1'b1, 32'h300, 8'h10, 6'd33},
        // R6 level 6
        '{1'b0, 1'b0, 1'b1, 4'd6, 8'h85, 6'd0,  1'b1, 32'h280, 8'h96, 6'd33}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge, let the commit edge pass, drop requests.
    task automatic fire(input logic d, input logic e, input logic i, input logic [3:0] lvl,
                        input logic [7:0] p, input logic [5:0] c, input logic [31:0] at_pc);
        @(negedge clk);
        dbg_req   = d;
        exc_req   = e;
        irq_req   = i;
        irq_level = lvl;
        ps        = p;
        exc_cause = c;
        pc        = at_pc;
        @(negedge clk);
        dbg_req        = 1'b0;
        exc_req        = 1'b0;
        irq_req        = 1'b0;
        exc_addr_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 taken",    32'(taken),    32'h0);
        check("R1 vector",   vector,        32'h0);
        check("R1 ps",       32'(ps_out),   32'h0);
        check("R1 epc bank", 32'(|epc_bank), 32'h0);
        check("R1 eps bank", 32'(|eps_bank), 32'h0);
        check("R1 causes",   32'({exccause, dbgcause}), 32'h0);
        check("R1 depc",     depc | excvaddr, 32'h0);
        rst_n = 1'b1;

        dbg_cause = 6'h11;
        for (int r = 0; r < NROWS; r++) begin
            fire(ROWS[r].dbg, ROWS[r].exc, ROWS[r].irq, ROWS[r].lvl,
                 ROWS[r].ps, ROWS[r].cause, 32'h1000 + 32'(r) * 4);
            check($sformatf("row %0d taken", r),  32'(taken),    32'(ROWS[r].tk));
            check($sformatf("row %0d vector", r), vector,        VB + ROWS[r].off);
            check($sformatf("row %0d ps", r),     32'(ps_out),   32'(ROWS[r].eps));
            check($sformatf("row %0d cause", r),  32'(exccause), 32'(ROWS[r].ecause));
        end

        // R5 faulting address captured, then held
        exc_addr_valid = 1'b1;
        exc_addr = 32'hDEAD_0000;
        fire(1'b0, 1'b1, 1'b0, 4'd0, 8'h00, 6'd15, 32'h0000_2000);
        check("R5 vaddr written", excvaddr, 32'hDEAD_0000);
        exc_addr = 32'h0000_1234;
        fire(1'b0, 1'b1, 1'b0, 4'd0, 8'h00, 6'd16, 32'h0000_9990);
        check("R5 vaddr kept", excvaddr, 32'hDEAD_0000);
        // R2 level-1 PC
        check("R2 epc level1", epc_bank[0 +: 32], 32'h0000_9990);

        // R4 double PC register
        fire(1'b0, 1'b1, 1'b0, 4'd0, 8'h10, 6'd17, 32'h0000_5550);
        check("R4 depc", depc, 32'h0000_5550);
        check("R4 epc level1 kept", epc_bank[0 +: 32], 32'h0000_9990);

        // R6 bank entries for level 3
        fire(1'b0, 1'b0, 1'b1, 4'd3, 8'h41, 6'd0, 32'h0000_7770);
        check("R6 epc level3", epc_bank[2*32 +: 32], 32'h0000_7770);
        check("R6 eps level3", 32'(eps_bank[1*8 +: 8]), 32'h41);

        // R9 debug bank entries and cause
        dbg_cause = 6'h2A;
        fire(1'b1, 1'b0, 1'b0, 4'd0, 8'h02, 6'd0, 32'h0000_8880);
        check("R9 epc level6", epc_bank[5*32 +: 32], 32'h0000_8880);
        check("R9 eps level6", 32'(eps_bank[4*8 +: 8]), 32'h02);
        check("R9 dbgcause", 32'(dbgcause), 32'h2A);

        // R13 request during the taken cycle is ignored
        fire(1'b0, 1'b1, 1'b0, 4'd0, 8'h00, 6'd20, 32'h0000_3000);
        check("R13 taken pulse", 32'(taken), 32'h1);
        exc_req   = 1'b1;
        exc_cause = 6'd21;
        @(negedge clk);
        exc_req = 1'b0;
        check("R13 taken low", 32'(taken), 32'h0);
        check("R13 cause kept", 32'(exccause), 32'd20);

        // R12 relocation against a base equal to the default
        vecbase = DEFB;
        fire(1'b0, 1'b1, 1'b0, 4'd0, 8'h20, 6'd2, 32'h0000_4000);
        check("R12 vector default base", vector, 32'h4000_0340);

        @(negedge clk);
        finish_run();
    end

endmodule